// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that counts on its own free-running clock, apart from the main system clock. Because it does not depend on the main clock, it keeps counting while the core clock is halted in a low-power state. A base counter expires after a parameterised number of ticks. A power-of-two prescaler can be placed in front of that counter to stretch the period by up to 128 times. The prescaler is shared with another timer, so an assignment bit chooses which of the two receives it.

Software restarts the count with a clear strobe. A strobe on entry to sleep restarts it as well. Both strobes come from the main clock domain and cross into the watchdog domain through a handshake, so no pulse is lost. When the count expires, the event crosses back into the main domain. There it becomes a one-cycle device-reset request if the core is running, or a one-cycle wake-up request if the core is asleep. A time-out status flag records the event, and a configuration enable held low disables the watchdog entirely.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, rst_req_o and wake_req_o are 0 and to_flag_o is 1.
- R2: With pre_to_wdt_i = 0, a time-out occurs BASE_CNT watchdog-clock cycles after the restart takes effect, whatever the value of pre_ratio_i.
- R3: With pre_to_wdt_i = 1, pre_ratio_i = k (0..7) divides the watchdog clock by 2^k, so the period becomes BASE_CNT * 2^k watchdog-clock cycles.
- R4: The clear strobe clr_wdt_i restarts both the base counter and the prescaler, so clears issued more often than the period prevent any time-out.
- R5: The sleep-entry strobe sleep_cmd_i restarts the counter and the prescaler in the same way as a clear.
- R6: A time-out with sleep_mode_i = 0 raises rst_req_o for exactly one main-clock cycle, and wake_req_o stays 0.
- R7: A time-out with sleep_mode_i = 1 raises wake_req_o for exactly one main-clock cycle, and rst_req_o stays 0.
- R8: to_flag_o goes to 0 on a time-out. It goes to 1 in the cycle after a clear or sleep-entry strobe.
- R9: While wdt_en_i = 0, neither rst_req_o nor wake_req_o is ever asserted.
- R10: A strobe lasting one main-clock cycle always restarts the count. A second strobe that arrives while the first is still in transit is delivered as a later restart, not dropped.
- R11: The count keeps advancing while clk_i is stopped. A time-out that occurs during the stop is reported within a few cycles after clk_i restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock, may stop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdt_clk_i | input | 1 | Free-running watchdog clock |
| wdt_en_i | input | 1 | Configuration enable, 0 disables permanently |
| clr_wdt_i | input | 1 | Software clear strobe (main domain) |
| sleep_cmd_i | input | 1 | Sleep-entry strobe (main domain) |
| sleep_mode_i | input | 1 | 1 while the core is asleep |
| pre_to_wdt_i | input | 1 | 1 assigns the prescaler to the watchdog |
| pre_ratio_i | input | 3 | Prescaler ratio, divide by 2^value |
| rst_req_o | output | 1 | One-cycle device-reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| to_flag_o | output | 1 | Time-out status, 0 after a time-out |

## Verification
The main function is exercised with every prescaler ratio, first with the prescaler assigned to the watchdog and then to the other timer. Because each doubling of the divider moves the expiry time well beyond the window allowed for clock-domain crossing, a measured period identifies which divider is actually in effect. Random mixes of sleep mode and strobe type distinguish the reset path from the wake path, and show that the clear strobe and the sleep-entry strobe restart the count in the same way. Directed cases cover a stream of clears that must hold off any time-out, two strobes issued back to back, a stopped main clock, and the disabled configuration.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RATIO_W = 3;
  localparam int PRE_W   = (1 << RATIO_W) - 1;

  function automatic logic [PRE_W-1:0] ratio_mask(input logic [RATIO_W-1:0] r);
    ratio_mask = PRE_W'((1 << r) - 1);
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wdt_clr_xfer.sv
// Toggle handshake: main-domain strobes become single watchdog-domain restart pulses.
module wdt_clr_xfer (
  input  logic clk_i,
  input  logic wdt_clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic clr_o
);
  logic pend_q, req_q, ack_q, ack_s, req_s;
  logic want, idle, launch;

  wdt_sync #(.W(1)) i_ack_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));
  wdt_sync #(.W(1)) i_req_sync (.clk_i(wdt_clk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s));

  assign want   = pend_q | strobe_i;
  assign idle   = (req_q == ack_s);
  assign launch = want & idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= want & ~launch;
      req_q  <= req_q ^ launch;
    end
  end

  always_ff @(posedge wdt_clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_s;
  end

  assign clr_o = req_s ^ ack_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != ack_s) |=> $stable(req_q));
  // R10
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (req_q != ack_s)) |=> pend_q);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BASE_CNT = 18,
  localparam int BASE_W  = (BASE_CNT > 2) ? $clog2(BASE_CNT) : 1
) (
  input  logic                         wdt_clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         psa_i,
  input  logic [wdt_pkg::RATIO_W-1:0]  ratio_i,
  input  logic                         clr_i,
  output logic                         exp_tgl_o
);
  import wdt_pkg::*;

  logic [PRE_W-1:0]  pre_q, mask;
  logic [BASE_W-1:0] base_q;
  logic              tick, last, expire, tgl_q;

  assign mask   = ratio_mask(ratio_i);
  assign tick   = ~psa_i | ((pre_q & mask) == mask);
  assign last   = (base_q == BASE_W'(BASE_CNT - 1));
  assign expire = en_i & ~clr_i & tick & last;

  always_ff @(posedge wdt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      base_q <= '0;
    end else if (!en_i || clr_i) begin
      pre_q  <= '0;
      base_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) base_q <= last ? '0 : base_q + 1'b1;
    end
  end

  always_ff @(posedge wdt_clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgl_q <= 1'b0;
    else if (expire) tgl_q <= ~tgl_q;
  end

  assign exp_tgl_o = tgl_q;

  // R2
  wrap_after_exp_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    expire |=> (base_q == '0));
  // R4
  clr_restart_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    clr_i |=> (base_q == '0 && pre_q == '0));
  // R9
  disabled_idle_chk: assert property (@(posedge wdt_clk_i) disable iff (!rst_ni)
    !en_i |=> (base_q == '0 && $stable(tgl_q)));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int BASE_CNT = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdt_clk_i,
  input  logic       wdt_en_i,
  input  logic       clr_wdt_i,
  input  logic       sleep_cmd_i,
  input  logic       sleep_mode_i,
  input  logic       pre_to_wdt_i,
  input  logic [2:0] pre_ratio_i,
  output logic       rst_req_o,
  output logic       wake_req_o,
  output logic       to_flag_o
);
  import wdt_pkg::*;

  localparam int CFG_W = 2 + RATIO_W;

  logic [CFG_W-1:0]   cfg_w;
  logic               en_w, psa_w;
  logic [RATIO_W-1:0] ratio_w;
  logic               strobe, clr_w, exp_tgl, exp_s, exp_d, exp_pulse;
  logic               rst_q, wake_q, to_q;

  assign strobe = clr_wdt_i | sleep_cmd_i;

  wdt_sync #(.W(CFG_W)) i_cfg_sync (
    .clk_i(wdt_clk_i), .rst_ni(rst_ni),
    .d_i({wdt_en_i, pre_to_wdt_i, pre_ratio_i}), .q_o(cfg_w)
  );
  assign {en_w, psa_w, ratio_w} = cfg_w;

  wdt_clr_xfer i_clr_xfer (
    .clk_i(clk_i), .wdt_clk_i(wdt_clk_i), .rst_ni(rst_ni),
    .strobe_i(strobe), .clr_o(clr_w)
  );

  wdt_count #(.BASE_CNT(BASE_CNT)) i_count (
    .wdt_clk_i(wdt_clk_i), .rst_ni(rst_ni), .en_i(en_w), .psa_i(psa_w),
    .ratio_i(ratio_w), .clr_i(clr_w), .exp_tgl_o(exp_tgl)
  );

  wdt_sync #(.W(1)) i_exp_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(exp_tgl), .q_o(exp_s));

  assign exp_pulse = exp_s ^ exp_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_d  <= 1'b0;
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
      to_q   <= 1'b1;
    end else begin
      exp_d  <= exp_s;
      rst_q  <= exp_pulse & ~sleep_mode_i;
      wake_q <= exp_pulse & sleep_mode_i;
      if (strobe)         to_q <= 1'b1;
      else if (exp_pulse) to_q <= 1'b0;
    end
  end

  assign rst_req_o  = rst_q;
  assign wake_req_o = wake_q;
  assign to_flag_o  = to_q;

  // R6
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R7
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |=> !wake_req_o);
  // R6
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && wake_req_o));
  // R6
  rst_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(!sleep_mode_i));
  // R8
  to_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(to_flag_o) |-> $past(exp_s != exp_d));
endmodule

// File: tb/test_wdt_prescaled.sv
module test_wdt_prescaled;
  localparam int  CLK_P = 10;
  localparam int  WDT_P = 14;
  localparam int  BASE  = 18;

  logic clk = 1'b0, wclk = 1'b0, clk_run = 1'b1;
  logic rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0, scmd = 1'b0, smode = 1'b0, asg = 1'b0;
  logic [2:0] ratio = 3'd0;
  logic rst_req, wake_req, to_flag;
  int n_tests = 0, n_fail = 0;

  always #(CLK_P/2) clk = clk_run ? ~clk : 1'b0;
  always #(WDT_P/2) wclk = ~wclk;

  wdt_prescaled #(.BASE_CNT(BASE)) i_wdt_prescaled (
    .clk_i(clk), .rst_ni(rst_n), .wdt_clk_i(wclk), .wdt_en_i(en),
    .clr_wdt_i(clr), .sleep_cmd_i(scmd), .sleep_mode_i(smode),
    .pre_to_wdt_i(asg), .pre_ratio_i(ratio),
    .rst_req_o(rst_req), .wake_req_o(wake_req), .to_flag_o(to_flag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint period_ns(input int r, input bit a);
    return longint'(BASE) * (a ? (longint'(1) << r) : 1) * WDT_P;
  endfunction

  task automatic strobe(input bit use_sleep);
    if (use_sleep) scmd = 1'b1; else clr = 1'b1;
    @(negedge clk);
    scmd = 1'b0; clr = 1'b0;
  endtask

  // returns delay from strobe to request, -1 if none within limit
  task automatic wait_req(input longint t0, input longint limit_ns, output longint d);
    d = -1;
    while ($time - t0 < limit_ns) begin
      @(negedge clk);
      if (rst_req || wake_req) begin d = $time - t0; break; end
    end
  endtask

  task automatic run_case(input int r, input bit a, input bit sm, input bit use_sleep,
                          input string req, input longint extra);
    longint t0, d, lo, hi;
    bit was_rst, was_wake;
    @(negedge clk);
    ratio = 3'(r); asg = a; smode = sm;
    repeat (4) @(negedge clk);
    t0 = $time;
    strobe(use_sleep);
    check(to_flag == 1'b1, use_sleep ? "R5/R8 flag set" : "R8 flag set", to_flag, 1);
    lo = period_ns(r, a);
    hi = lo + 6*WDT_P + 6*CLK_P + extra;
    wait_req(t0, hi + 20*CLK_P, d);
    was_rst = rst_req; was_wake = wake_req;
    check(d >= lo && d <= hi, req, d, lo);
    check(sm ? (was_wake && !was_rst) : (was_rst && !was_wake),
          sm ? "R7 wake path" : "R6 reset path", {was_rst, was_wake}, sm ? 1 : 2);
    check(to_flag == 1'b0, "R8 flag clear", to_flag, 0);
    @(negedge clk);
    check(!rst_req && !wake_req, "R6/R7 one-cycle pulse", {rst_req, wake_req}, 0);
  endtask

  initial begin
    #(longint'(CLK_P) * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    longint d, t0;
    bit seen;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1
    check(!rst_req && !wake_req && to_flag, "R1 reset state", {rst_req, wake_req, to_flag}, 1);
    rst_n = 1'b1;
    // R9: disabled, long wait
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rst_req || wake_req) seen = 1'b1;
    end
    check(!seen, "R9 disabled never fires", seen, 0);
    en = 1'b1;
    // R2: not assigned, ratio ignored
    run_case(0, 1'b0, 1'b0, 1'b0, "R2 base period", 0);
    run_case(7, 1'b0, 1'b0, 1'b0, "R2 ratio ignored unassigned", 0);
    // R3: each ratio assigned
    for (int k = 1; k < 8; k++) run_case(k, 1'b1, 1'b0, 1'b0, "R3 prescaled period", 0);
    // R5 / R7 directed
    run_case(2, 1'b1, 1'b1, 1'b1, "R5 sleep strobe restart", 0);
    // random mix
    for (int i = 0; i < 10; i++) begin
      int r; bit a, sm, us;
      r = int'($urandom % 8); a = 1'($urandom); sm = 1'($urandom); us = 1'($urandom);
      if (r > 5) r = r - 2;
      run_case(r, a, sm, us, "R3 random period", 0);
    end
    // R4: clears faster than the period hold off time-outs
    @(negedge clk); ratio = 3'd0; asg = 1'b0; smode = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      strobe(1'b0);
      for (int j = 0; j < 9; j++) begin
        @(negedge clk);
        if (rst_req || wake_req) seen = 1'b1;
      end
    end
    check(!seen, "R4 periodic clear prevents time-out", seen, 0);
    // R10: two back-to-back strobes, measured from the second
    @(negedge clk); clr = 1'b1;
    @(negedge clk); t0 = $time;
    @(negedge clk); clr = 1'b0;
    wait_req(t0, period_ns(0, 1'b0) + 30*CLK_P + 12*WDT_P, d);
    check(d >= period_ns(0, 1'b0) && rst_req, "R10 second strobe kept", d, period_ns(0, 1'b0));
    // R11: stop main clock across one expiry
    repeat (2) @(negedge clk);
    strobe(1'b0);
    clk_run = 1'b0;
    #(period_ns(0, 1'b0) + 100);
    clk_run = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    check(seen, "R11 expiry during clock stop", seen, 1);
    check(to_flag == 1'b0, "R11 flag after stop", to_flag, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule